// File: doc/BRIEF.md
# Whole-Element Word Packer

This block takes a stream of fixed-size data elements and gathers them into 64-bit words for a DMA channel. The element size is set at elaboration, from 1 to 8 bytes. A word carries as many whole elements as fit in it. An element is never split between two words. Any byte of a word that carries no element is driven to a configurable filler constant.

Sizes that divide 64 bits fill the word exactly: 1-byte elements go 8 to a word, 2-byte elements 4, 4-byte elements 2 and 8-byte elements 1. Any other size wastes the tail of each word. A 5-byte element, for example, takes a whole word, and the top 3 bytes are filler.

Both the element side and the word side use a valid/ready handshake. An element moves when `in_valid` and `in_ready` are both high at a rising edge. A word moves when `out_valid` and `out_ready` are both high at a rising edge. The rules for back-pressure are these:
- While `out_valid` is high and `out_ready` is low, the output word and its count hold still.
- `in_ready` never depends on `in_valid`. It drops only when accepting an element, or obeying `flush`, would need the output register while that register is still occupied.

`flush` is a plain level input. In any cycle where the output register can take a word, `flush` sends out the partial word early, padded, if that word would hold at least one element.

Top module: `elem_word_packer`

## Requirements
- R1: The number of slots per word is the integer part of 8 divided by ELEM_BYTES. A ELEM_BYTES value outside 1..8 is an elaboration error. With 2-byte elements, a word is emitted after every fourth accepted element, and it carries a count of 4.
- R2: Slot k of a word occupies bytes k*ELEM_BYTES up to (k+1)*ELEM_BYTES-1 of `out_data`. Byte 0 is bits 7:0. Slot 0 holds the oldest element of the word, so elements keep their arrival order.
- R3: Every byte of `out_data` that holds no valid element equals FILL_BYTE. This covers unused slots and the tail bytes past the last slot. With 5-byte elements, bytes 5..7 are always filler.
- R4: When an element is accepted into the last free slot, the full word appears on `out_valid`/`out_data` after the next rising edge.
- R5: When `flush` is high in a cycle where the output register is free (`out_valid` low or `out_ready` high), a word is emitted after that edge. The word holds the elements already collected, plus any element accepted in that same cycle.
- R6: When `flush` is high while nothing is held and no element is accepted, no word is produced.
- R7: `out_count` gives the number of valid elements in the emitted word. It ranges from 1 to the slot count and is meaningful while `out_valid` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_count` stay unchanged on the following cycle.
- R9: `in_ready` is low in two cases, each only when the output register is occupied and not being drained. The first is when the next element would complete a word. The second is when `flush` is high. In every other case `in_ready` is high. No element is ever dropped or reordered.
- R10: A synchronous active-high `rst` empties the partial word and clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Element offered |
| in_ready | output | 1 | Element can be taken this cycle |
| in_data | input | 8*ELEM_BYTES | Element, least significant byte first |
| flush | input | 1 | Emit the partial word early |
| out_valid | output | 1 | Packed word is present |
| out_ready | input | 1 | DMA channel takes the word |
| out_data | output | 64 | Packed word |
| out_count | output | 4 | Valid elements in the word |

## Verification
Two instances run side by side from the same stimulus. One uses 2-byte elements with a zero filler. The other uses 5-byte elements with a non-zero filler, which shows whether the tail padding is correct and whether words are emitted one element at a time.

The tests cover the following patterns:
- A steady stream with the output always ready. This separates correct lane order and word boundaries from an off-by-one in the slot count.
- Single elements followed by `flush`, and `flush` with nothing held. These separate padding of unused slots from stale data, and an early emit from a spurious empty word.
- A stretch with the output stalled, followed by a long random mix of valid, flush and ready with one reset in the middle. This exposes lost or duplicated elements under back-pressure, and any state that survives a reset.

// File: rtl/pk_pkg.sv
package pk_pkg;
  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned WORD_W     = 8 * WORD_BYTES;
  localparam int unsigned CNT_W      = 4;

  function automatic int unsigned slots_for(input int unsigned eb);
    return WORD_BYTES / eb;
  endfunction
endpackage

// File: rtl/pk_slot_ctrl.sv
module pk_slot_ctrl
  import pk_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             flush,
  input  logic             out_free,
  output logic             in_ready,
  output logic             in_fire,
  output logic             emit,
  output logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] emit_count
);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);

  logic             at_last;
  logic [CNT_W-1:0] fill_q;
  logic [CNT_W-1:0] total;

  assign at_last    = (fill_q == LAST_SLOT);
  // Accepting into the last slot, or flushing, both need the output register.
  assign in_ready   = out_free || (!flush && !at_last);
  assign in_fire    = in_valid && in_ready;
  assign total      = fill_q + CNT_W'(in_fire);
  assign emit       = out_free && ((in_fire && at_last) || (flush && (total != '0)));
  assign emit_count = total;
  assign fill       = fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
    end else if (emit) begin
      fill_q <= '0;
    end else if (in_fire) begin
      fill_q <= fill_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pk_lane_store.sv
module pk_lane_store
  import pk_pkg::*;
#(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned ELEM_W = 16
) (
  input  logic                    clk,
  input  logic                    in_fire,
  input  logic [CNT_W-1:0]        fill,
  input  logic [ELEM_W-1:0]       in_data,
  output logic [SLOTS*ELEM_W-1:0] held
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [ELEM_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (in_fire && (fill == CNT_W'(s))) begin
        slot_q <= in_data;
      end
    end
    assign held[s*ELEM_W +: ELEM_W] = slot_q;
  end
endmodule

// File: rtl/pk_word_build.sv
module pk_word_build
  import pk_pkg::*;
#(
  parameter int unsigned ELEM_BYTES = 2,
  parameter int unsigned SLOTS      = 4,
  parameter logic [7:0]  FILL_BYTE  = 8'h00
) (
  input  logic [SLOTS*ELEM_BYTES*8-1:0] held,
  input  logic [CNT_W-1:0]              fill,
  input  logic                          in_fire,
  input  logic [ELEM_BYTES*8-1:0]       in_data,
  output logic [WORD_W-1:0]             word
);
  localparam int unsigned ELEM_W     = ELEM_BYTES * 8;
  localparam int unsigned USED_BYTES = SLOTS * ELEM_BYTES;
  localparam int unsigned USED_W     = USED_BYTES * 8;
  localparam int unsigned TAIL_BYTES = WORD_BYTES - USED_BYTES;

  localparam logic [ELEM_W-1:0] ELEM_FILL = {ELEM_BYTES{FILL_BYTE}};

  for (genvar s = 0; s < SLOTS; s++) begin : g_lane
    logic held_live;
    logic new_here;
    assign held_live = (CNT_W'(s) < fill);
    assign new_here  = in_fire && (CNT_W'(s) == fill);
    assign word[s*ELEM_W +: ELEM_W] =
        held_live ? held[s*ELEM_W +: ELEM_W] :
        new_here  ? in_data : ELEM_FILL;
  end

  if (TAIL_BYTES > 0) begin : g_tail
    assign word[WORD_W-1:USED_W] = {TAIL_BYTES{FILL_BYTE}};
  end
endmodule

// File: rtl/pk_out_reg.sv
module pk_out_reg
  import pk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  count,
  input  logic              out_ready,
  output logic              out_free,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [CNT_W-1:0]  out_count
);
  assign out_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_count <= '0;
    end else if (emit) begin
      out_data  <= word;
      out_count <= count;
    end
  end
endmodule

// File: rtl/elem_word_packer.sv
module elem_word_packer
  import pk_pkg::*;
#(
  parameter int unsigned ELEM_BYTES = 2,
  parameter logic [7:0]  FILL_BYTE  = 8'h00
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ELEM_BYTES*8-1:0] in_data,
  input  logic                    flush,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W-1:0]       out_data,
  output logic [CNT_W-1:0]        out_count
);
  localparam int unsigned ELEM_W = ELEM_BYTES * 8;
  localparam int unsigned SLOTS  = slots_for(ELEM_BYTES);

  if (ELEM_BYTES < 1 || ELEM_BYTES > WORD_BYTES) begin : g_bad_size
    $error("elem_word_packer: ELEM_BYTES must be within 1..8");
  end

  logic                    out_free;
  logic                    in_fire;
  logic                    emit;
  logic [CNT_W-1:0]        fill;
  logic [CNT_W-1:0]        emit_count;
  logic [SLOTS*ELEM_W-1:0] held;
  logic [WORD_W-1:0]       word;

  pk_slot_ctrl #(.SLOTS(SLOTS)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .flush      (flush),
    .out_free   (out_free),
    .in_ready   (in_ready),
    .in_fire    (in_fire),
    .emit       (emit),
    .fill       (fill),
    .emit_count (emit_count)
  );

  pk_lane_store #(.SLOTS(SLOTS), .ELEM_W(ELEM_W)) store_i (
    .clk     (clk),
    .in_fire (in_fire),
    .fill    (fill),
    .in_data (in_data),
    .held    (held)
  );

  pk_word_build #(
    .ELEM_BYTES (ELEM_BYTES),
    .SLOTS      (SLOTS),
    .FILL_BYTE  (FILL_BYTE)
  ) build_i (
    .held    (held),
    .fill    (fill),
    .in_fire (in_fire),
    .in_data (in_data),
    .word    (word)
  );

  pk_out_reg oreg_i (
    .clk       (clk),
    .rst       (rst),
    .emit      (emit),
    .word      (word),
    .count     (emit_count),
    .out_ready (out_ready),
    .out_free  (out_free),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_count (out_count)
  );
endmodule

// File: rtl/elem_word_packer_chk.sv
module elem_word_packer_chk
  import pk_pkg::*;
#(
  parameter int unsigned ELEM_BYTES = 2,
  parameter logic [7:0]  FILL_BYTE  = 8'h00
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              flush,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic [CNT_W-1:0]  out_count,
  input logic [CNT_W-1:0]  fill
);
  localparam int unsigned SLOTS = slots_for(ELEM_BYTES);

  logic pad_ok;
  always_comb begin
    pad_ok = 1'b1;
    for (int b = 0; b < int'(WORD_BYTES); b++) begin
      if (b >= int'(out_count) * int'(ELEM_BYTES) && out_data[8*b +: 8] != FILL_BYTE) begin
        pad_ok = 1'b0;
      end
    end
  end

  assert_pad_filler_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> pad_ok);

  assert_count_range_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_count >= CNT_W'(1)) && (out_count <= CNT_W'(SLOTS)));

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_count)));

  assert_stall_full_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && fill == CNT_W'(SLOTS - 1)) |-> !in_ready);

  assert_full_emit_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && fill == CNT_W'(SLOTS - 1)) |=> (out_valid && out_count == CNT_W'(SLOTS)));

  assert_empty_flush_R6: assert property (@(posedge clk) disable iff (rst)
    (flush && fill == '0 && !in_valid && (!out_valid || out_ready)) |=> !out_valid);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && fill == '0));
endmodule

bind elem_word_packer elem_word_packer_chk #(
  .ELEM_BYTES (ELEM_BYTES),
  .FILL_BYTE  (FILL_BYTE)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .flush     (flush),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_count (out_count),
  .fill      (fill)
);

// File: tb/elem_word_packer_tb_top.sv
module pk_ref_model #(
  parameter int         EB   = 2,
  parameter logic [7:0] FILL = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        flush,
  input  logic        out_ready,
  input  logic [63:0] in_data,
  output logic        exp_valid,
  output logic [63:0] exp_data,
  output logic [3:0]  exp_count,
  output logic        exp_ready
);
  localparam int SL = 8 / EB;
  logic [63:0] q[$];
  logic [63:0] items[$];
  logic [63:0] mask;
  logic [63:0] w;
  logic        fire, free, emit;

  initial begin
    exp_valid = 1'b0;
    exp_data  = '0;
    exp_count = '0;
    mask      = (EB == 8) ? '1 : ((64'h1 << (8 * EB)) - 64'h1);
  end

  always_comb exp_ready = (!exp_valid || out_ready) || (!flush && q.size() != SL - 1);

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      exp_valid = 1'b0;
    end else begin
      free  = !exp_valid || out_ready;
      fire  = in_valid && exp_ready;
      items = q;
      if (fire) items.push_back(in_data & mask);
      emit = free && ((fire && q.size() == SL - 1) || (flush && items.size() > 0));
      if (emit) begin
        w = {8{FILL}};
        for (int i = 0; i < items.size(); i++)
          for (int b = 0; b < EB; b++)
            w[8*(i*EB+b) +: 8] = items[i][8*b +: 8];
        exp_data  = w;
        exp_count = 4'(items.size());
        exp_valid = 1'b1;
        q.delete();
      end else begin
        if (fire) q.push_back(in_data & mask);
        if (free) exp_valid = 1'b0;
      end
    end
  end
endmodule

module elem_word_packer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, in_valid, flush, out_ready;
  logic [63:0] stim;
  int          compared = 0;
  int          mismatched = 0;
  bit          chk_on = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        a_in_ready, a_out_valid, b_in_ready, b_out_valid;
  logic [63:0] a_out_data, b_out_data;
  logic [3:0]  a_out_count, b_out_count;
  logic        ra_valid, ra_ready, rb_valid, rb_ready;
  logic [63:0] ra_data, rb_data;
  logic [3:0]  ra_count, rb_count;

  elem_word_packer #(.ELEM_BYTES(2)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(a_in_ready),
    .in_data(stim[15:0]), .flush(flush), .out_valid(a_out_valid),
    .out_ready(out_ready), .out_data(a_out_data), .out_count(a_out_count));

  elem_word_packer #(.ELEM_BYTES(5), .FILL_BYTE(8'hA5)) dut5_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(b_in_ready),
    .in_data(stim[39:0]), .flush(flush), .out_valid(b_out_valid),
    .out_ready(out_ready), .out_data(b_out_data), .out_count(b_out_count));

  pk_ref_model #(.EB(2)) ref_a (
    .clk(clk), .rst(rst), .in_valid(in_valid), .flush(flush), .out_ready(out_ready),
    .in_data(stim), .exp_valid(ra_valid), .exp_data(ra_data), .exp_count(ra_count),
    .exp_ready(ra_ready));

  pk_ref_model #(.EB(5), .FILL(8'hA5)) ref_b (
    .clk(clk), .rst(rst), .in_valid(in_valid), .flush(flush), .out_ready(out_ready),
    .in_data(stim), .exp_valid(rb_valid), .exp_data(rb_data), .exp_count(rb_count),
    .exp_ready(rb_ready));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    check(a_out_valid === ra_valid, "R4", "eb2 out_valid", 64'(a_out_valid), 64'(ra_valid));
    check(b_out_valid === rb_valid, "R4", "eb5 out_valid", 64'(b_out_valid), 64'(rb_valid));
    if (ra_valid) begin
      check(a_out_data === ra_data, "R2", "eb2 out_data", a_out_data, ra_data);
      check(a_out_count === ra_count, "R7", "eb2 out_count", 64'(a_out_count), 64'(ra_count));
    end
    if (rb_valid) begin
      check(b_out_data === rb_data, "R3", "eb5 out_data", b_out_data, rb_data);
      check(b_out_count === rb_count, "R7", "eb5 out_count", 64'(b_out_count), 64'(rb_count));
    end
  endtask

  task automatic step(input logic v, input logic fl, input logic rdy,
                      input logic r, input logic [63:0] d);
    @(negedge clk);
    if (chk_on) compare_outputs();
    rst = r; in_valid = v; flush = fl; out_ready = rdy; stim = d;
    #1;
    if (chk_on) begin
      check(a_in_ready === ra_ready, "R9", "eb2 in_ready", 64'(a_in_ready), 64'(ra_ready));
      check(b_in_ready === rb_ready, "R9", "eb5 in_ready", 64'(b_in_ready), 64'(rb_ready));
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [63:0] hold_word;
    rst = 1'b1; in_valid = 1'b0; flush = 1'b0; out_ready = 1'b1; stim = '0;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 64'h0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 64'h0);
    chk_on = 1'b1;
    settle();
    // R10: reset leaves nothing pending
    check(!a_out_valid && !b_out_valid, "R10", "out_valid after reset", 64'(a_out_valid), 64'h0);
    check(a_in_ready && b_in_ready, "R10", "in_ready after reset", 64'(a_in_ready), 64'h1);

    // R1 R2: four 2-byte elements form one word, oldest in the lowest lanes
    step(1'b1, 1'b0, 1'b1, 1'b0, 64'h1111);
    step(1'b1, 1'b0, 1'b1, 1'b0, 64'h2222);
    step(1'b1, 1'b0, 1'b1, 1'b0, 64'h3333);
    step(1'b1, 1'b0, 1'b1, 1'b0, 64'h4444);
    settle();
    check(a_out_valid && a_out_count == 4'd4, "R1", "eb2 four per word", 64'(a_out_count), 64'h4);
    check(a_out_data == 64'h4444_3333_2222_1111, "R2", "eb2 lane order", a_out_data, 64'h4444_3333_2222_1111);

    // R5: one element then flush gives a padded word of count 1
    step(1'b1, 1'b0, 1'b1, 1'b0, 64'hABCD);
    step(1'b0, 1'b1, 1'b1, 1'b0, 64'h0);
    settle();
    check(a_out_valid && a_out_count == 4'd1, "R5", "eb2 flush count", 64'(a_out_count), 64'h1);
    check(a_out_data == 64'h0000_0000_0000_ABCD, "R5", "eb2 flush data", a_out_data, 64'hABCD);

    // R6: flush with nothing held yields no word
    step(1'b0, 1'b1, 1'b1, 1'b0, 64'h0);
    settle();
    check(!a_out_valid && !b_out_valid, "R6", "empty flush", 64'(a_out_valid), 64'h0);

    // R3: a 5-byte element leaves three filler bytes on top
    step(1'b1, 1'b0, 1'b1, 1'b0, 64'h0000_0001_0203_0405);
    settle();
    check(b_out_valid && b_out_count == 4'd1, "R3", "eb5 one per word", 64'(b_out_count), 64'h1);
    check(b_out_data == 64'hA5A5A5_0102030405, "R3", "eb5 filler", b_out_data, 64'hA5A5A5_0102030405);

    // R8 R9: stalled output holds its word and blocks the completing element
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 64'(i + 'h50));
    settle();
    hold_word = a_out_data;
    check(!a_in_ready, "R9", "eb2 stall", 64'(a_in_ready), 64'h0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 64'h77);
    settle();
    check(a_out_valid && a_out_data == hold_word, "R8", "eb2 held word", a_out_data, hold_word);

    // Mixed random traffic against the reference, one reset in the middle (R10)
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 3) != 0,
           i == 2000, {$urandom, $urandom});
    step(1'b0, 1'b0, 1'b1, 1'b0, 64'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule